// File: doc/BRIEF.md
# Integer Add/Subtract Unit with Flags

This block is the add and subtract slice of a 64-bit integer execution pipe. It takes a 3-bit operation code, two 64-bit register operands, a 16-bit immediate and the architectural carry pair and sticky overflow bit as they stand before the instruction. One clock after a valid strobe it presents the 64-bit sum, a new carry pair, an optional signed overflow with the updated sticky overflow, and a 4-bit condition field. Companion write-enable outputs tell the surrounding pipeline whether the carry pair and the condition field are to be committed.

Eight operations share one 64-bit adder: add, subtract-from (second operand minus first, formed as the inverted first operand plus the second plus one), add-immediate, add-immediate-shifted, subtract-from-immediate, add-extended, add-to-minus-one and add-to-zero. The last three take the stored carry as carry-in. Operand selection, flag logic and the adder are separate submodules, and all results are held in one bank of output registers.

Top module: `int_addsub_unit`

## Requirements
- R1: Operation codes are ADD=0, SUBF=1, ADDI=2, ADDIS=3, SUBFIC=4, ADDE=5, ADDME=6, ADDZE=7. ADD returns a+b and SUBF returns b-a, both modulo 2^64.
- R2: ADDI returns a plus the sign-extended immediate. ADDIS returns a plus the immediate placed in bits 31:16 and sign-extended from bit 31. For both, in_ra_zero=1 replaces a with zero.
- R3: SUBFIC returns the sign-extended immediate minus a, modulo 2^64.
- R4: ADDE returns a+b+in_ca, ADDME returns a+(2^64-1)+in_ca, and ADDZE returns a+in_ca. in_ca is the carry-in of these three forms only.
- R5: out_ca[0] is the carry out of bit 63 and out_ca[1] the carry out of bit 31 of the same addition, carry-in included. out_ca_we is 1 for SUBFIC, ADDE, ADDME and ADDZE and 0 for the other four codes.
- R6: With in_ovf_en=1, out_ov is 1 exactly when the true signed result does not fit in 64 bits. With in_ovf_en=0, out_ov is 0.
- R7: out_so equals in_so OR out_ov. A set in_so is never cleared by the unit.
- R8: out_cr is {bit 3: result bit 63 set, bit 2: result positive and nonzero, bit 1: result zero, bit 0: out_so}. Bit 0 carries in_so even when the current operation has no overflow. out_cr_we equals in_rec.
- R9: All outputs are registered. out_done pulses for one cycle, one clock after each in_valid. With no in_valid the outputs hold their last value. Synchronous reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 3 | Operation code (see R1) |
| in_ra_zero | input | 1 | Use zero instead of a for ADDI/ADDIS |
| in_a | input | 64 | First operand |
| in_b | input | 64 | Second operand |
| in_imm | input | 16 | Immediate field |
| in_ovf_en | input | 1 | Enable overflow detection |
| in_rec | input | 1 | Request condition-field update |
| in_ca | input | 1 | Stored carry bit (carry-in) |
| in_so | input | 1 | Stored sticky overflow bit |
| out_done | output | 1 | Result valid pulse |
| out_result | output | 64 | 64-bit result |
| out_ca | output | 2 | {carry out of bit 31, carry out of bit 63} |
| out_ca_we | output | 1 | Carry pair is to be committed |
| out_ov | output | 1 | Signed overflow |
| out_so | output | 1 | Updated sticky overflow |
| out_cr | output | 4 | Condition field |
| out_cr_we | output | 1 | Condition field is to be committed |

## Verification
Fixed vectors separate operand order in subtract-from, show whether the stored carry reaches only the three carry-consuming forms, and cover both sides of the carry-in on add-to-minus-one at 0x7ffffffff. Sign-boundary operands such as 0x7fffffffffffffff+1, the most negative value with carry-in 0 and all-ones plus carry, separate overflow from carry and exercise the zero and negative condition bits. Overflow detection is run both enabled and disabled, and a record operation with sticky overflow already set shows the copy into bit 0. A randomized stream of all eight codes, with back-to-back strobes, is checked against a signed 66-bit reference.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

    parameter int unsigned XLEN  = 64;
    parameter int unsigned IMM_W = 16;
    localparam int unsigned HALF   = XLEN / 2;
    localparam int unsigned OP_W   = 3;
    localparam int unsigned CR_W   = 4;
    localparam int unsigned SHIFTI = 16;

    typedef enum logic [OP_W-1:0] {
        OP_ADD    = 3'd0,
        OP_SUBF   = 3'd1,
        OP_ADDI   = 3'd2,
        OP_ADDIS  = 3'd3,
        OP_SUBFIC = 3'd4,
        OP_ADDE   = 3'd5,
        OP_ADDME  = 3'd6,
        OP_ADDZE  = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic [XLEN-1:0] x;
        logic [XLEN-1:0] y;
        logic            cin;
        logic            ca_we;
    } addend_t;

    typedef struct packed {
        logic [XLEN-1:0] sum;
        logic            co_full;
        logic            co_half;
        logic            ovf;
    } sum_t;

    typedef struct packed {
        logic            ov;
        logic            so;
        logic [CR_W-1:0] cr;
    } flags_t;

    function automatic logic [XLEN-1:0] sext_imm(input logic [IMM_W-1:0] imm);
        return {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
    endfunction

    function automatic logic [XLEN-1:0] sext_imm_hi(input logic [IMM_W-1:0] imm);
        return {{(XLEN-IMM_W-SHIFTI){imm[IMM_W-1]}}, imm, {SHIFTI{1'b0}}};
    endfunction

endpackage

// File: rtl/addsub_opsel.sv
module addsub_opsel
    import addsub_pkg::*;
(
    input  alu_op_e         op,
    input  logic            ra_zero,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic [IMM_W-1:0] imm,
    input  logic            ca_in,
    output addend_t         addend
);
    logic [XLEN-1:0] a_or_zero;

    always_comb begin
        a_or_zero = ra_zero ? '0 : a;
        addend    = '0;
        unique case (op)
            OP_ADD: begin
                addend.x = a;
                addend.y = b;
            end
            OP_SUBF: begin
                addend.x   = ~a;
                addend.y   = b;
                addend.cin = 1'b1;
            end
            OP_ADDI: begin
                addend.x = a_or_zero;
                addend.y = sext_imm(imm);
            end
            OP_ADDIS: begin
                addend.x = a_or_zero;
                addend.y = sext_imm_hi(imm);
            end
            OP_SUBFIC: begin
                addend.x     = ~a;
                addend.y     = sext_imm(imm);
                addend.cin   = 1'b1;
                addend.ca_we = 1'b1;
            end
            OP_ADDE: begin
                addend.x     = a;
                addend.y     = b;
                addend.cin   = ca_in;
                addend.ca_we = 1'b1;
            end
            OP_ADDME: begin
                addend.x     = a;
                addend.y     = '1;
                addend.cin   = ca_in;
                addend.ca_we = 1'b1;
            end
            OP_ADDZE: begin
                addend.x     = a;
                addend.y     = '0;
                addend.cin   = ca_in;
                addend.ca_we = 1'b1;
            end
            default: addend = '0;
        endcase
    end
endmodule

// File: rtl/addsub_adder.sv
module addsub_adder
    import addsub_pkg::*;
(
    input  addend_t addend,
    output sum_t    result
);
    logic [HALF:0] low_sum;
    logic [HALF:0] high_sum;

    always_comb begin
        low_sum  = {1'b0, addend.x[HALF-1:0]} + {1'b0, addend.y[HALF-1:0]}
                 + {{HALF{1'b0}}, addend.cin};
        high_sum = {1'b0, addend.x[XLEN-1:HALF]} + {1'b0, addend.y[XLEN-1:HALF]}
                 + {{HALF{1'b0}}, low_sum[HALF]};
        result.sum     = {high_sum[HALF-1:0], low_sum[HALF-1:0]};
        result.co_full = high_sum[HALF];
        result.co_half = low_sum[HALF];
        result.ovf     = (addend.x[XLEN-1] == addend.y[XLEN-1]) &&
                         (result.sum[XLEN-1] != addend.x[XLEN-1]);
    end
endmodule

// File: rtl/addsub_flags.sv
module addsub_flags
    import addsub_pkg::*;
(
    input  sum_t   sres,
    input  logic   ovf_en,
    input  logic   so_in,
    output flags_t flags
);
    logic neg, zero;

    always_comb begin
        neg      = sres.sum[XLEN-1];
        zero     = (sres.sum == '0);
        flags.ov = ovf_en & sres.ovf;
        flags.so = so_in | flags.ov;
        flags.cr = {neg, ~neg & ~zero, zero, flags.so};
    end
endmodule

// File: rtl/int_addsub_unit.sv
module int_addsub_unit
    import addsub_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [OP_W-1:0]  in_op,
    input  logic             in_ra_zero,
    input  logic [XLEN-1:0]  in_a,
    input  logic [XLEN-1:0]  in_b,
    input  logic [IMM_W-1:0] in_imm,
    input  logic             in_ovf_en,
    input  logic             in_rec,
    input  logic             in_ca,
    input  logic             in_so,
    output logic             out_done,
    output logic [XLEN-1:0]  out_result,
    output logic [1:0]       out_ca,
    output logic             out_ca_we,
    output logic             out_ov,
    output logic             out_so,
    output logic [CR_W-1:0]  out_cr,
    output logic             out_cr_we
);
    alu_op_e op;
    addend_t addend;
    sum_t    sres;
    flags_t  flags;

    assign op = alu_op_e'(in_op);

    addsub_opsel u_opsel (
        .op      (op),
        .ra_zero (in_ra_zero),
        .a       (in_a),
        .b       (in_b),
        .imm     (in_imm),
        .ca_in   (in_ca),
        .addend  (addend)
    );

    addsub_adder u_adder (
        .addend (addend),
        .result (sres)
    );

    addsub_flags u_flags (
        .sres   (sres),
        .ovf_en (in_ovf_en),
        .so_in  (in_so),
        .flags  (flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_done   <= 1'b0;
            out_result <= '0;
            out_ca     <= '0;
            out_ca_we  <= 1'b0;
            out_ov     <= 1'b0;
            out_so     <= 1'b0;
            out_cr     <= '0;
            out_cr_we  <= 1'b0;
        end else begin
            out_done <= in_valid;
            if (in_valid) begin
                out_result <= sres.sum;
                out_ca     <= {sres.co_half, sres.co_full};
                out_ca_we  <= addend.ca_we;
                out_ov     <= flags.ov;
                out_so     <= flags.so;
                out_cr     <= flags.cr;
                out_cr_we  <= in_rec;
            end
        end
    end
endmodule

// File: rtl/addsub_checker.sv
module addsub_checker
    import addsub_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [OP_W-1:0]  in_op,
    input logic             in_ovf_en,
    input logic             in_rec,
    input logic             in_so,
    input logic             out_done,
    input logic [XLEN-1:0]  out_result,
    input logic             out_ca_we,
    input logic             out_ov,
    input logic             out_so,
    input logic [CR_W-1:0]  out_cr,
    input logic             out_cr_we
);
    a_r9_done_after_valid: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_done);

    a_r9_no_spurious_done: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_done);

    a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_result));

    a_r7_so_sticky: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_so) |=> out_so);

    a_r7_ov_implies_so: assert property (@(posedge clk) disable iff (rst)
        out_ov |-> out_so);

    a_r6_ov_gated: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_ovf_en) |=> !out_ov);

    a_r8_cr_so_copy: assert property (@(posedge clk) disable iff (rst)
        out_done |-> (out_cr[0] == out_so));

    a_r8_cr_one_sign: assert property (@(posedge clk) disable iff (rst)
        out_done |-> ($countones(out_cr[3:1]) == 1));

    a_r8_cr_we_follows_rec: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_cr_we == $past(in_rec)));

    a_r5_no_carry_for_plain_add: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op inside {3'd0, 3'd1, 3'd2, 3'd3}) |=> !out_ca_we);

    a_r5_carry_for_extended: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op inside {3'd4, 3'd5, 3'd6, 3'd7}) |=> out_ca_we);
endmodule

bind int_addsub_unit addsub_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_op      (in_op),
    .in_ovf_en  (in_ovf_en),
    .in_rec     (in_rec),
    .in_so      (in_so),
    .out_done   (out_done),
    .out_result (out_result),
    .out_ca_we  (out_ca_we),
    .out_ov     (out_ov),
    .out_so     (out_so),
    .out_cr     (out_cr),
    .out_cr_we  (out_cr_we)
);

// File: tb/int_addsub_unit_test.sv
`timescale 1ns/1ps
module int_addsub_unit_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_ra_zero, in_ovf_en, in_rec, in_ca, in_so;
    logic [2:0]  in_op;
    logic [63:0] in_a, in_b;
    logic [15:0] in_imm;
    logic        out_done, out_ca_we, out_ov, out_so, out_cr_we;
    logic [63:0] out_result;
    logic [1:0]  out_ca;
    logic [3:0]  out_cr;

    int checks = 0;
    int fails  = 0;
    bit done_run = 0;

    typedef struct {
        logic [63:0] res;
        logic [1:0]  ca;
        logic        ca_we;
        logic        ov;
        logic        so;
        logic [3:0]  cr;
        logic        cr_we;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #5 clk = ~clk;

    int_addsub_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_ra_zero(in_ra_zero), .in_a(in_a), .in_b(in_b), .in_imm(in_imm),
        .in_ovf_en(in_ovf_en), .in_rec(in_rec), .in_ca(in_ca), .in_so(in_so),
        .out_done(out_done), .out_result(out_result), .out_ca(out_ca),
        .out_ca_we(out_ca_we), .out_ov(out_ov), .out_so(out_so),
        .out_cr(out_cr), .out_cr_we(out_cr_we)
    );

    function automatic logic [65:0] sx(input logic [63:0] v);
        return {{2{v[63]}}, v};
    endfunction

    // Reference model: signed 66-bit arithmetic, carries from unsigned comparisons.
    function automatic exp_t model(input logic [2:0] op, input logic rz,
                                   input logic [63:0] a, input logic [63:0] b,
                                   input logic [15:0] imm, input logic ovf,
                                   input logic rec, input logic ca, input logic so,
                                   input string tag);
        exp_t e;
        logic [65:0] r;
        logic [63:0] i64, ihi, base;
        logic [64:0] u;
        logic [32:0] u32;
        i64  = {{48{imm[15]}}, imm};
        ihi  = {{32{imm[15]}}, imm, 16'h0};
        base = rz ? 64'd0 : a;
        e.ca = 2'b00;
        e.ca_we = 1'b0;
        case (op)
            3'd0: r = sx(a) + sx(b);
            3'd1: r = sx(b) - sx(a);
            3'd2: r = sx(base) + sx(i64);
            3'd3: r = sx(base) + sx(ihi);
            3'd4: begin
                r = sx(i64) - sx(a);
                e.ca = {i64[31:0] >= a[31:0], i64 >= a};
                e.ca_we = 1'b1;
            end
            3'd5: begin
                r   = sx(a) + sx(b) + {65'd0, ca};
                u   = {1'b0, a} + {1'b0, b} + {64'd0, ca};
                u32 = {1'b0, a[31:0]} + {1'b0, b[31:0]} + {32'd0, ca};
                e.ca = {u32[32], u[64]};
                e.ca_we = 1'b1;
            end
            3'd6: begin
                r = sx(a) - 66'd1 + {65'd0, ca};
                e.ca = {(a[31:0] != 0) || ca, (a != 0) || ca};
                e.ca_we = 1'b1;
            end
            default: begin
                r = sx(a) + {65'd0, ca};
                e.ca = {ca && (a[31:0] == 32'hffffffff), ca && (a == '1)};
                e.ca_we = 1'b1;
            end
        endcase
        e.res   = r[63:0];
        e.ov    = ovf && (r[64] != r[63]);
        e.so    = so || e.ov;
        e.cr    = {e.res[63], !e.res[63] && (e.res != 0), e.res == 0, e.so};
        e.cr_we = rec;
        e.tag   = tag;
        return e;
    endfunction

    task automatic drive(input logic [2:0] op, input logic rz,
                         input logic [63:0] a, input logic [63:0] b,
                         input logic [15:0] imm, input logic ovf, input logic rec,
                         input logic ca, input logic so, input string tag);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_ra_zero = rz; in_a = a; in_b = b;
        in_imm = imm; in_ovf_en = ovf; in_rec = rec; in_ca = ca; in_so = so;
        sb.push_back(model(op, rz, a, b, imm, ovf, rec, ca, so, tag));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: pops one expected item per done pulse.
    always @(negedge clk) begin
        if (!rst && out_done) begin
            exp_t e;
            bit bad;
            checks++;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL R9: done with no pending item, result %h exp none", out_result);
            end else begin
                e = sb.pop_front();
                bad = (out_result !== e.res) || (out_ov !== e.ov) || (out_so !== e.so) ||
                      (out_cr !== e.cr) || (out_cr_we !== e.cr_we) ||
                      (out_ca_we !== e.ca_we) || (e.ca_we && out_ca !== e.ca);
                if (bad) begin
                    fails++;
                    $display("FAIL %s: got res=%h ca=%b/%b ov=%b so=%b cr=%b/%b exp res=%h ca=%b/%b ov=%b so=%b cr=%b/%b",
                             e.tag, out_result, out_ca, out_ca_we, out_ov, out_so, out_cr, out_cr_we,
                             e.res, e.ca, e.ca_we, e.ov, e.so, e.cr, e.cr_we);
                end
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done_run) begin
            fails++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] held;
        rst = 1'b1; in_valid = 1'b0; in_op = '0; in_ra_zero = 1'b0; in_a = '0;
        in_b = '0; in_imm = '0; in_ovf_en = 1'b0; in_rec = 1'b0; in_ca = 1'b0; in_so = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (out_done !== 1'b0 || out_result !== '0 || out_cr !== '0 || out_so !== 1'b0) begin
            fails++;
            $display("FAIL R9 reset: got done=%b res=%h cr=%b so=%b exp all zero",
                     out_done, out_result, out_cr, out_so);
        end
        rst = 1'b0;

        // R1 add and subtract-from ordering
        drive(3'd0, 0, 64'h2e08ae202742baf8, 64'h86c43ece9efe5baa, 0, 0, 1, 0, 0, "R1 add");
        drive(3'd1, 0, 64'h3d7f3f7ca24bac7b, 64'hf6b2ac5e13ee15c2, 0, 0, 0, 0, 0, "R1 subf");
        drive(3'd1, 0, 64'h10, 64'h05, 0, 0, 1, 0, 0, "R1 subf negative");
        // R2 immediates
        drive(3'd2, 1, 64'hdeadbeef, 0, 16'hffa0, 0, 0, 0, 0, "R2 addi ra_zero");
        drive(3'd3, 1, 64'h1234, 0, 16'h0001, 0, 0, 0, 0, "R2 addis ra_zero");
        drive(3'd3, 0, 64'h100, 0, 16'h8000, 0, 1, 0, 0, "R2 addis negative");
        drive(3'd2, 0, 64'h7f9497aaff900ea0, 0, 16'h8001, 0, 0, 0, 0, "R2 addi");
        // R3 subtract-from-immediate, carries R5
        drive(3'd4, 0, 64'h5, 0, 16'h0003, 0, 1, 0, 0, "R3 subfic borrow");
        drive(3'd4, 0, 64'h3, 0, 16'hfffd, 0, 0, 0, 0, "R3 subfic neg imm");
        // R4 carry-consuming forms
        drive(3'd6, 0, 64'h7ffffffff, 0, 0, 0, 0, 0, 0, "R4 addme ca0");
        drive(3'd6, 0, 64'h7ffffffff, 0, 0, 0, 0, 1, 0, "R4 addme ca1");
        drive(3'd5, 0, 64'hffffffffffffffff, 64'h0, 0, 0, 1, 1, 0, "R4 adde wrap zero");
        drive(3'd7, 0, 64'h00ff00ff00ff0080, 0, 0, 0, 0, 0, 0, "R4 addze ca0");
        drive(3'd7, 0, 64'hffffffffffffffff, 0, 0, 1, 1, 1, 0, "R4 addze all ones");
        drive(3'd0, 0, 64'h1, 64'h2, 0, 0, 0, 1, 0, "R4 add ignores carry-in");
        // R5 half carry alone
        drive(3'd5, 0, 64'h00000000ffffffff, 64'h1, 0, 0, 0, 0, 0, "R5 half carry");
        // R6 overflow enabled / disabled
        drive(3'd0, 0, 64'h7fffffffffffffff, 64'h1, 0, 1, 1, 0, 0, "R6 add ovf");
        drive(3'd0, 0, 64'h7fffffffffffffff, 64'h1, 0, 0, 1, 0, 0, "R6 add ovf disabled");
        drive(3'd6, 0, 64'h8000000000000000, 0, 0, 1, 1, 0, 0, "R6 addme min");
        drive(3'd6, 0, 64'h7fffffffffffffff, 0, 0, 1, 1, 1, 0, "R6 addme no ovf");
        drive(3'd1, 0, 64'h1, 64'h8000000000000000, 0, 1, 0, 0, 0, "R6 subf ovf");
        // R7 / R8 sticky copy without overflow
        drive(3'd6, 0, 64'h7ffffffff, 0, 0, 0, 1, 1, 1, "R8 so copy");
        drive(3'd0, 0, 64'h5, 64'h5, 0, 1, 1, 0, 1, "R7 so kept");
        idle(2);
        // R9 hold: outputs unchanged while idle
        held = 64'h0000000000000000 + 64'ha;
        idle(3);
        checks++;
        if (out_done !== 1'b0 || out_result !== held) begin
            fails++;
            $display("FAIL R9 hold: got done=%b res=%h exp done=0 res=%h", out_done, out_result, held);
        end
        // random stream, back to back
        for (int i = 0; i < 60; i++) begin
            drive(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
                  {$urandom, $urandom}, {$urandom, $urandom}, 16'($urandom),
                  1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                  1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R1-random R6");
            if (i % 7 == 0) idle(1);
        end
        idle(4);
        checks++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R9 drain: got %0d pending exp 0", sb.size());
        end
        done_run = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule